// File: doc/BRIEF.md
# Up/Down Timer with Event Capture

A 16-bit general-purpose timer controlled through a small synchronous register port. The counter steps up or down once per prescaled tick. In free-running mode it sweeps the whole range and wraps to the far end. In periodic mode it starts from a programmable load value and returns to that value after each terminal count. A prescaler divides the incoming tick strobe by 1, 4, 16 or 256.

When the count arrives at its terminal value (0xFFFF counting up, 0 counting down), a timeout flag and the interrupt output go high. They stay high until software writes a clear. An optional reload-on-clear control makes that same clear write restart the count at once, so a new load value takes effect without waiting for the next timeout. A capture unit watches one of 32 event inputs, picked by a 5-bit selector. On the first rising edge of the selected input it latches the live count, and the timer keeps running.

A second count view is passed through a two-stage synchronizer. It models a safe read path that lags the direct count by two cycles.

Top module: `gp_updown_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. A read returns on `bus_rdata` one cycle after `bus_addr` is presented. The register addresses are: 0 control, 1 load, 2 count, 3 synchronized count, 4 capture, 5 status, 6 clear.
- R2: On the cycle after a control write sets the enable bit (bit 4) from 0 to 1, the count holds its start value. The start value is the load value in periodic mode (bit 3 = 1), 0 in free-running up mode, and 0xFFFF in free-running down mode. Direction is bit 2: 1 counts up, 0 counts down.
- R3: Control bits [1:0] select a prescale of 1, 4, 16 or 256 (codes 0, 1, 2, 3). The counter steps once per that many `tick` cycles. Ticks have no effect while the timer is disabled.
- R4: In periodic mode the counter moves toward the terminal value. The step taken at the terminal value loads the load value.
- R5: The step that brings the count to its terminal value sets status bit 0 and `irq`. Writing 1 to clear bit 0 drops both. That write does not move the count while control bit 7 is 0.
- R6: In free-running mode the step taken at the terminal value wraps the count to the opposite end (0xFFFF down to the next step gives 0xFFFF after 0; up gives 0 after 0xFFFF).
- R7: With control bit 7 set, a write of 1 to clear bit 0 reloads the start value immediately, in either mode.
- R8: While the timer is enabled, load writes are ignored and a control write changes only the enable bit.
- R9: With control bit 8 set, the first rising edge of `evt_in[sel]` (sel = control bits [13:9]) copies the count into the capture register and sets status bit 1. Further edges do not recapture until clear bit 1 is written with 1. The count keeps running.
- R10: Edges on unselected event inputs, or any edge while control bit 8 is 0, leave the capture register and status bit 1 unchanged.
- R11: The synchronized count read equals the direct count as it was two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tick | input | 1 | Tick strobe that feeds the prescaler |
| evt_in | input | 32 | Event inputs for capture |
| irq | output | 1 | Timeout interrupt, registered |

## Verification
A write takes effect at the clock edge that samples it, with one exception. Enabling the timer loads the start value one edge later. A counter step lands at the edge where a qualifying tick is sampled. Read data appears one edge after the address.

The bench drives every input at a falling edge and lets a task pulse ticks for an exact number of edges. Each expected read is queued before its address is presented. A monitor pops it at the falling edge after the registering edge. The synchronizer lag is checked with two reads spaced two cycles apart under a continuous tick, which must return the same value.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [2:0] {
    A_CTRL      = 3'd0,
    A_LOAD      = 3'd1,
    A_COUNT     = 3'd2,
    A_COUNT_SYN = 3'd3,
    A_CAPTURE   = 3'd4,
    A_STATUS    = 3'd5,
    A_CLEAR     = 3'd6
  } reg_addr_e;

  // control field positions
  localparam int B_PRE   = 0;
  localparam int B_UP    = 2;
  localparam int B_PER   = 3;
  localparam int B_EN    = 4;
  localparam int B_RLC   = 7;
  localparam int B_CAPEN = 8;
  localparam int B_SEL   = 9;

  // log2 of the prescale ratio for each code: 1, 4, 16, 256
  function automatic int unsigned pre_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       step
);
  import gpt_pkg::*;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    lim  = PW'((32'd1 << pre_shift(sel)) - 32'd1);
    step = en & tick & ~restart & (pcnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= (pcnt == lim) ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         periodic,
  input  logic         up,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         clr_reload,
  output logic [W-1:0] count,
  output logic         restart,
  output logic         hit
);
  logic         en_d;
  logic         first;
  logic [W-1:0] term;
  logic [W-1:0] start;
  logic [W-1:0] nxt;

  always_comb begin
    first   = en & ~en_d;
    restart = first | clr_reload;
    term    = up ? '1 : '0;
    start   = periodic ? load_val : (up ? '0 : '1);
    nxt     = up ? count + 1'b1 : count - 1'b1;
    hit     = en & ~restart & step & (count != term) & (nxt == term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      en_d  <= 1'b0;
    end else begin
      en_d <= en;
      if (en) begin
        if (restart) begin
          count <= start;
        end else if (step) begin
          count <= (count == term) ? start : nxt;
        end
      end
    end
  end
endmodule

// File: rtl/gpt_capture.sv
module gpt_capture #(
  parameter int W    = 16,
  parameter int EV_N = 32,
  localparam int EV_SW = $clog2(EV_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [EV_SW-1:0] sel,
  input  logic [EV_N-1:0]  evt,
  input  logic [W-1:0]     count,
  input  logic             clr_flag,
  output logic [W-1:0]     cap_val,
  output logic             flag
);
  logic [EV_N-1:0] hot;
  logic            sel_evt;
  logic            evt_q;
  logic            take;

  genvar i;
  generate
    for (i = 0; i < EV_N; i++) begin : g_dec
      assign hot[i] = evt[i] & (sel == EV_SW'(i));
    end
  endgenerate

  always_comb begin
    sel_evt = |hot;
    take    = cap_en & sel_evt & ~evt_q & ~flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q   <= 1'b0;
      flag    <= 1'b0;
      cap_val <= '0;
    end else begin
      evt_q <= sel_evt;
      if (take) begin
        cap_val <= count;
        flag    <= 1'b1;
      end else if (clr_flag) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES+1];

  assign stg[0] = d;

  genvar s;
  generate
    for (s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES];
endmodule

// File: rtl/gp_updown_timer.sv
module gp_updown_timer #(
  parameter int CNT_W       = 16,
  parameter int EV_N        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             tick,
  input  logic [EV_N-1:0]  evt_in,
  output logic             irq
);
  import gpt_pkg::*;

  localparam int EV_SW = $clog2(EV_N);
  localparam logic [CNT_W-1:0] EN_MASK   = CNT_W'(1) << B_EN;
  localparam logic [CNT_W-1:0] SEL_MASK  = CNT_W'((1 << EV_SW) - 1) << B_SEL;
  localparam logic [CNT_W-1:0] CTRL_MASK = SEL_MASK | (CNT_W'(1) << B_CAPEN) |
                                           (CNT_W'(1) << B_RLC) | EN_MASK |
                                           (CNT_W'(1) << B_PER) | (CNT_W'(1) << B_UP) |
                                           CNT_W'(3);

  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic             tmo_q;
  logic             ctrl_en;
  logic             wr_ctrl, wr_load, wr_clr;
  logic             clr_tmo, clr_cap, clr_reload;
  logic             step, restart, hit;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] cnt_sync_w;
  logic [CNT_W-1:0] cap_val;
  logic             cap_flag;

  always_comb begin
    ctrl_en    = ctrl_q[B_EN];
    wr_ctrl    = bus_wr & (bus_addr == A_CTRL);
    wr_load    = bus_wr & (bus_addr == A_LOAD);
    wr_clr     = bus_wr & (bus_addr == A_CLEAR);
    clr_tmo    = wr_clr & bus_wdata[0];
    clr_cap    = wr_clr & bus_wdata[1];
    clr_reload = clr_tmo & ctrl_q[B_RLC] & ctrl_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      tmo_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (ctrl_en) ctrl_q <= (ctrl_q & ~EN_MASK) | (bus_wdata & EN_MASK);
        else         ctrl_q <= bus_wdata & CTRL_MASK;
      end
      if (wr_load && !ctrl_en) load_q <= bus_wdata;
      if (hit)          tmo_q <= 1'b1;
      else if (clr_tmo) tmo_q <= 1'b0;
    end
  end

  assign irq = tmo_q;

  gpt_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(ctrl_en), .restart(restart),
    .tick(tick), .sel(ctrl_q[B_PRE +: 2]), .step(step)
  );

  gpt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl_en), .periodic(ctrl_q[B_PER]),
    .up(ctrl_q[B_UP]), .load_val(load_q), .step(step),
    .clr_reload(clr_reload), .count(count_w), .restart(restart), .hit(hit)
  );

  gpt_capture #(.W(CNT_W), .EV_N(EV_N)) u_cap (
    .clk(clk), .rst(rst), .cap_en(ctrl_q[B_CAPEN]),
    .sel(ctrl_q[B_SEL +: EV_SW]), .evt(evt_in), .count(count_w),
    .clr_flag(clr_cap), .cap_val(cap_val), .flag(cap_flag)
  );

  gpt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(count_w), .q(cnt_sync_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:      bus_rdata <= ctrl_q;
        A_LOAD:      bus_rdata <= load_q;
        A_COUNT:     bus_rdata <= count_w;
        A_COUNT_SYN: bus_rdata <= cnt_sync_w;
        A_CAPTURE:   bus_rdata <= cap_val;
        A_STATUS:    bus_rdata <= {{(CNT_W-2){1'b0}}, cap_flag, tmo_q};
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         irq,
  input logic         en,
  input logic         cap_en,
  input logic         cap_flag,
  input logic [W-1:0] count,
  input logic [W-1:0] count_sync,
  input logic [W-1:0] load_q,
  input logic [W-1:0] cap_val
);
  // R5: a fresh timeout always coincides with a terminal count
  a_r5_rise_at_term: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (count == '0 || count == '1));

  // R3: a disabled timer holds its count across the next edge
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  // R8: the load register cannot change while the timer runs
  a_r8_load_locked: assert property (@(posedge clk) disable iff (rst)
    en |=> $stable(load_q));

  // R9: only the first selected edge captures until the flag is cleared
  a_r9_first_only: assert property (@(posedge clk) disable iff (rst)
    cap_flag |=> $stable(cap_val));

  // R10: with capture off nothing is latched
  a_r10_no_capture_off: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(cap_val));

  // R11: synchronized view trails the live count by two cycles
  a_r11_sync_lag: assert property (@(posedge clk) disable iff (rst)
    count_sync == $past(count, 2));
endmodule

bind gp_updown_timer gpt_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .en(ctrl_en), .cap_en(ctrl_q[8]),
  .cap_flag(cap_flag), .count(count_w), .count_sync(cnt_sync_w),
  .load_q(load_q), .cap_val(cap_val)
);

// File: tb/tb_gp_updown_timer.sv
module tb_gp_updown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick = 1'b0;
  logic [31:0] evt_in = '0;
  logic        irq;

  gp_updown_timer dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .evt_in(evt_in), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_chk = 0;
  int    n_err = 0;
  logic  rd_req = 1'b0;
  logic  rd_q = 1'b0;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  always @(posedge clk) rd_q <= rd_req;

  // monitor: compare each registered read with the queued expectation
  always @(negedge clk) begin
    if (rd_q) begin
      if (sb.size() == 0) begin
        check("scoreboard underflow", 16'h0, 16'h1);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    bus_addr = a; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic tick_run(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic evt_pulse(input int idx);
    @(negedge clk);
    evt_in[idx] = 1'b1;
    @(negedge clk);
    evt_in[idx] = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v, s;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq after reset", {15'h0, irq}, 16'h0);
    rd_exp(3'd0, 16'h0000, "R1 ctrl reset");
    rd_exp(3'd2, 16'h0000, "R1 count reset");
    rd_exp(3'd5, 16'h0000, "R1 status reset");

    // R2/R4/R5 periodic down, load 5, prescale 1
    wr(3'd1, 16'd5);
    wr(3'd0, 16'h0018);
    rd_exp(3'd2, 16'd5, "R2 periodic start = load");
    tick_run(5);
    rd_exp(3'd2, 16'd0, "R4 periodic reaches zero");
    check("R5 irq at terminal", {15'h0, irq}, 16'h1);
    rd_exp(3'd5, 16'h0001, "R5 status bit0 set");
    tick_run(1);
    rd_exp(3'd2, 16'd5, "R4 periodic reload");
    wr(3'd6, 16'h0001);
    check("R5 irq cleared", {15'h0, irq}, 16'h0);
    rd_exp(3'd5, 16'h0000, "R5 status cleared");
    rd_exp(3'd2, 16'd5, "R5 clear without bit7 keeps count");

    // R8 write protection while enabled
    wr(3'd1, 16'd9);
    rd_exp(3'd1, 16'd5, "R8 load write ignored");
    wr(3'd0, 16'h0000);
    rd_exp(3'd0, 16'h0008, "R8 only enable bit changed");
    tick_run(3);
    rd_exp(3'd2, 16'd5, "R3 ticks ignored while disabled");

    // R3 prescaler ratios, free-running up
    wr(3'd0, 16'h0015);
    rd_exp(3'd2, 16'd0, "R2 free up start = 0");
    tick_run(3);
    rd_exp(3'd2, 16'd0, "R3 div4 holds after 3");
    tick_run(1);
    rd_exp(3'd2, 16'd1, "R3 div4 steps on 4th");
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0016);
    tick_run(15);
    rd_exp(3'd2, 16'd0, "R3 div16 holds after 15");
    tick_run(1);
    rd_exp(3'd2, 16'd1, "R3 div16 steps on 16th");
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0017);
    tick_run(255);
    rd_exp(3'd2, 16'd0, "R3 div256 holds after 255");
    tick_run(1);
    rd_exp(3'd2, 16'd1, "R3 div256 steps on 256th");

    // R6 free-running down full sweep
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0010);
    rd_exp(3'd2, 16'hFFFF, "R2 free down start = FFFF");
    tick_run(65535);
    rd_exp(3'd2, 16'h0000, "R6 free down reaches zero");
    check("R5 irq on free down terminal", {15'h0, irq}, 16'h1);
    tick_run(1);
    rd_exp(3'd2, 16'hFFFF, "R6 free down wraps to FFFF");
    wr(3'd6, 16'h0001);

    // R7 reload on clear
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd100);
    wr(3'd0, 16'h0098);
    tick_run(10);
    rd_exp(3'd2, 16'd90, "R7 periodic counted to 90");
    wr(3'd6, 16'h0001);
    rd_exp(3'd2, 16'd100, "R7 clear reloads load value");
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0094);
    tick_run(7);
    rd_exp(3'd2, 16'd7, "R7 free up counted to 7");
    wr(3'd6, 16'h0001);
    rd_exp(3'd2, 16'd0, "R7 clear reloads 0 in free up");

    // R9/R10 capture on event 17
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h2318);
    tick_run(3);
    evt_pulse(3);
    rd_exp(3'd4, 16'd0, "R10 unselected event ignored");
    rd_exp(3'd5, 16'h0000, "R10 no capture flag");
    evt_pulse(17);
    rd_exp(3'd4, 16'd97, "R9 capture latches count");
    rd_exp(3'd5, 16'h0002, "R9 capture flag set");
    tick_run(2);
    rd_exp(3'd2, 16'd95, "R9 counter keeps running");
    evt_pulse(17);
    rd_exp(3'd4, 16'd97, "R9 second edge ignored");
    wr(3'd6, 16'h0002);
    rd_exp(3'd5, 16'h0000, "R9 capture flag cleared");
    evt_pulse(17);
    rd_exp(3'd4, 16'd95, "R9 recapture after clear");
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h2208);
    wr(3'd6, 16'h0002);
    evt_pulse(17);
    rd_exp(3'd4, 16'd95, "R10 capture off ignores edge");
    rd_exp(3'd5, 16'h0000, "R10 capture off no flag");

    // R11 synchronized view lags by two cycles
    wr(3'd0, 16'h0014);
    @(negedge clk);
    tick = 1'b1;
    peek(3'd2, v);
    peek(3'd3, s);
    tick = 1'b0;
    check("R11 sync count two cycles behind", s, v);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 16'(sb.size()), 16'h0);
    finish_run();
  end
endmodule